// File: doc/BRIEF.md
# Compressed Instruction Decoder (RV64)

This block classifies a 16-bit compressed RISC-V instruction on a 64-bit core. For each instruction it reports the equivalent base operation, the memory access width in bytes, whether a load sign-extends, and whether the encoding is illegal. The front end presents the low half of a fetched instruction word with a valid strobe. One clock later the classification appears on a registered output stage.

Decoding starts from a five-bit row index made of the quadrant bits and the top three bits. Most rows map directly to one base operation. Three rows are resolved by secondary decoders. The register jump/move/add row uses bit 12 and whether each register field is zero. The upper-immediate row uses its destination register. The arithmetic-misc row uses bits 11:10 and, for register-register forms, bits 12 and 6:5. Compressed floating-point rows are reported illegal. Register field expansion and immediate reassembly are left to later stages.

Top module: `rvc_decoder`

## Requirements
- R1: While reset is asserted and right after it, out_valid, out_op, out_width, out_signed and out_illegal are all zero.
- R2: A result appears exactly one clock after its in_valid cycle, with out_valid high. A cycle with in_valid low yields out_valid low and all other outputs zero one clock later.
- R3: Quadrant 0 (instr[1:0]=00), with the row index {instr[1:0], instr[15:13]}: row 0 gives ADDI. Row 2 gives LOAD, width 4, signed. Row 3 gives LOAD, width 8, unsigned. Row 6 gives STORE, width 4. Row 7 gives STORE, width 8. Row 4 is illegal. out_signed is high only for 4-byte loads.
- R4: The floating-point rows 1, 5, 17 and 21 are illegal.
- R5: In quadrant 1: row 8 gives ADDI, row 9 gives ADDIW, row 10 gives ADDI, row 13 gives JAL, row 14 gives BEQ and row 15 gives BNE.
- R6: In row 11, a destination field instr[11:7] equal to 2 gives ADDI. A field equal to 0 is illegal. Any other value gives LUI.
- R7: In row 12, instr[11:10] values 0, 1 and 2 give SRLI, SRAI and ANDI.
- R8: In row 12 with instr[11:10]=3, the code {instr[12], instr[6:5]} values 0 to 5 give SUB, XOR, OR, AND, SUBW and ADDW. Codes 6 and 7 are illegal.
- R9: In quadrant 2: row 16 gives SLLI. Row 18 gives LOAD, width 4, signed. Row 19 gives LOAD, width 8. Row 22 gives STORE, width 4. Row 23 gives STORE, width 8.
- R10: In row 20, the code {instr[12]!=0, instr[11:7]!=0, instr[6:2]!=0} selects the result. Codes 010 and 110 give JALR. Codes 011 and 111 give ADD. All other codes are illegal.
- R11: The out_op codes are: 0 none/illegal, 1 ADDI, 2 ADDIW, 3 LUI, 4 SLLI, 5 SRLI, 6 SRAI, 7 ANDI, 8 ADD, 9 SUB, 10 XOR, 11 OR, 12 AND, 13 ADDW, 14 SUBW, 15 LOAD, 16 STORE, 17 JAL, 18 JALR, 19 BEQ, 20 BNE. out_width is the access size in bytes and is 0 for non-memory operations. An illegal result has out_illegal=1 with out_op, out_width and out_signed all zero.
- R12: No valid input has instr[1:0]=11. Such words belong to the 32-bit decoder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction strobe |
| in_instr | input | 16 | Compressed instruction |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| out_op | output | 5 | Base operation code |
| out_width | output | 4 | Memory access size in bytes |
| out_signed | output | 1 | Load sign-extends |
| out_illegal | output | 1 | Encoding is illegal |

## Verification
The hardest cases to reach are the boundaries of the register jump/move/add row. There, each of the eight zero/non-zero combinations of bit 12 and the two register fields must be built on purpose, because ordinary code rarely contains the illegal ones. The stimulus assembles every combination, and also the two spare register-register codes of the arithmetic row, from explicit field values. It then adds the zero destination in the upper-immediate row and drives these words back to back with idle cycles in between.

// File: rtl/rvc_dec_pkg.sv
package rvc_dec_pkg;
    localparam int INSN_W = 16;
    localparam int RF_W   = 5;
    localparam int OP_W   = 5;
    localparam int WID_W  = 4;
    localparam int ROW_W  = 5;

    typedef enum logic [OP_W-1:0] {
        OP_INV   = 5'd0,  OP_ADDI  = 5'd1,  OP_ADDIW = 5'd2,  OP_LUI  = 5'd3,
        OP_SLLI  = 5'd4,  OP_SRLI  = 5'd5,  OP_SRAI  = 5'd6,  OP_ANDI = 5'd7,
        OP_ADD   = 5'd8,  OP_SUB   = 5'd9,  OP_XOR   = 5'd10, OP_OR   = 5'd11,
        OP_AND   = 5'd12, OP_ADDW  = 5'd13, OP_SUBW  = 5'd14, OP_LOAD = 5'd15,
        OP_STORE = 5'd16, OP_JAL   = 5'd17, OP_JALR  = 5'd18, OP_BEQ  = 5'd19,
        OP_BNE   = 5'd20
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [WID_W-1:0] width;
        logic             sgn;
        logic             ill;
    } dec_t;

    localparam dec_t DEC_IDLE = '{op: OP_INV, width: '0, sgn: 1'b0, ill: 1'b0};
    localparam dec_t DEC_ILL  = '{op: OP_INV, width: '0, sgn: 1'b0, ill: 1'b1};

    function automatic dec_t dec_alu(op_e op);
        return '{op: op, width: '0, sgn: 1'b0, ill: 1'b0};
    endfunction

    function automatic dec_t dec_mem(op_e op, logic [WID_W-1:0] w, logic s);
        return '{op: op, width: w, sgn: s, ill: 1'b0};
    endfunction
endpackage

// File: rtl/rvc_cr_decode.sv
// Register jump / move / add row: keyed on which fields are non-zero.
module rvc_cr_decode
    import rvc_dec_pkg::*;
(
    input  logic            b12,
    input  logic [RF_W-1:0] rd_f,
    input  logic [RF_W-1:0] rs2_f,
    output dec_t            res
);
    logic [2:0] nz_code;

    always_comb begin
        nz_code = {b12, (rd_f != '0), (rs2_f != '0)};
        case (nz_code)
            3'b010:  res = dec_alu(OP_JALR);
            3'b011:  res = dec_alu(OP_ADD);
            3'b110:  res = dec_alu(OP_JALR);
            3'b111:  res = dec_alu(OP_ADD);
            default: res = DEC_ILL;
        endcase
    end
endmodule

// File: rtl/rvc_lui_decode.sv
// Upper-immediate row: destination field picks stack adjust vs. LUI.
module rvc_lui_decode
    import rvc_dec_pkg::*;
(
    input  logic [RF_W-1:0] rd_f,
    output dec_t            res
);
    localparam logic [RF_W-1:0] SP_IDX = RF_W'(2);

    always_comb begin
        if (rd_f == '0)
            res = DEC_ILL;
        else if (rd_f == SP_IDX)
            res = dec_alu(OP_ADDI);
        else
            res = dec_alu(OP_LUI);
    end
endmodule

// File: rtl/rvc_alu_decode.sv
// Arithmetic-misc row: shift/and-immediate forms and register-register forms.
module rvc_alu_decode
    import rvc_dec_pkg::*;
(
    input  logic       b12,
    input  logic [1:0] sel_hi,
    input  logic [1:0] sel_lo,
    output dec_t       res
);
    logic [2:0] rr_code;

    always_comb begin
        rr_code = {b12, sel_lo};
        res     = DEC_ILL;
        case (sel_hi)
            2'd0: res = dec_alu(OP_SRLI);
            2'd1: res = dec_alu(OP_SRAI);
            2'd2: res = dec_alu(OP_ANDI);
            default: begin
                case (rr_code)
                    3'd0:    res = dec_alu(OP_SUB);
                    3'd1:    res = dec_alu(OP_XOR);
                    3'd2:    res = dec_alu(OP_OR);
                    3'd3:    res = dec_alu(OP_AND);
                    3'd4:    res = dec_alu(OP_SUBW);
                    3'd5:    res = dec_alu(OP_ADDW);
                    default: res = DEC_ILL;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/rvc_decoder.sv
module rvc_decoder
    import rvc_dec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] in_instr,
    output logic              out_valid,
    output logic [OP_W-1:0]   out_op,
    output logic [WID_W-1:0]  out_width,
    output logic              out_signed,
    output logic              out_illegal
);
    typedef struct packed {
        logic vld;
        dec_t dec;
    } stage_t;

    localparam logic [WID_W-1:0] W4 = WID_W'(4);
    localparam logic [WID_W-1:0] W8 = WID_W'(8);

    stage_t          stage_d, stage_q;
    logic [ROW_W-1:0] row_idx;
    logic [RF_W-1:0] rd_f, rs2_f;
    dec_t            cr_res, lui_res, alu_res, row_res;

    assign row_idx = {in_instr[1:0], in_instr[15:13]};
    assign rd_f    = in_instr[11:7];
    assign rs2_f   = in_instr[6:2];

    rvc_cr_decode u_cr (
        .b12   (in_instr[12]),
        .rd_f  (rd_f),
        .rs2_f (rs2_f),
        .res   (cr_res)
    );

    rvc_lui_decode u_lui (
        .rd_f (rd_f),
        .res  (lui_res)
    );

    rvc_alu_decode u_alu (
        .b12    (in_instr[12]),
        .sel_hi (in_instr[11:10]),
        .sel_lo (in_instr[6:5]),
        .res    (alu_res)
    );

    always_comb begin
        case (row_idx)
            5'd0:    row_res = dec_alu(OP_ADDI);
            5'd2:    row_res = dec_mem(OP_LOAD, W4, 1'b1);
            5'd3:    row_res = dec_mem(OP_LOAD, W8, 1'b0);
            5'd6:    row_res = dec_mem(OP_STORE, W4, 1'b0);
            5'd7:    row_res = dec_mem(OP_STORE, W8, 1'b0);
            5'd8:    row_res = dec_alu(OP_ADDI);
            5'd9:    row_res = dec_alu(OP_ADDIW);
            5'd10:   row_res = dec_alu(OP_ADDI);
            5'd11:   row_res = lui_res;
            5'd12:   row_res = alu_res;
            5'd13:   row_res = dec_alu(OP_JAL);
            5'd14:   row_res = dec_alu(OP_BEQ);
            5'd15:   row_res = dec_alu(OP_BNE);
            5'd16:   row_res = dec_alu(OP_SLLI);
            5'd18:   row_res = dec_mem(OP_LOAD, W4, 1'b1);
            5'd19:   row_res = dec_mem(OP_LOAD, W8, 1'b0);
            5'd20:   row_res = cr_res;
            5'd22:   row_res = dec_mem(OP_STORE, W4, 1'b0);
            5'd23:   row_res = dec_mem(OP_STORE, W8, 1'b0);
            default: row_res = DEC_ILL;
        endcase
        stage_d.vld = in_valid;
        stage_d.dec = in_valid ? row_res : DEC_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '{vld: 1'b0, dec: DEC_IDLE};
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid   = stage_q.vld;
    assign out_op      = stage_q.dec.op;
    assign out_width   = stage_q.dec.width;
    assign out_signed  = stage_q.dec.sgn;
    assign out_illegal = stage_q.dec.ill;

    AST_NO_Q3_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> in_instr[1:0] != 2'b11); // R12
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_illegal && out_op == '0 && out_width == '0)); // R2
    AST_FP_ROWS_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (row_idx == 5'd1 || row_idx == 5'd5 || row_idx == 5'd17 || row_idx == 5'd21))
        |=> out_illegal); // R4
    AST_ILLEGAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_op == '0 && out_width == '0 && !out_signed)); // R11
    AST_SIGN_ONLY_W4: assert property (@(posedge clk) disable iff (!rst_n)
        out_signed |-> (out_width == W4 && out_op == OP_LOAD)); // R3
    AST_LUI_RD0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && row_idx == 5'd11 && rd_f == '0) |=> out_illegal); // R6
    AST_ALU_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && row_idx == 5'd12 && in_instr[11:10] == 2'b11 && in_instr[12] && in_instr[6])
        |=> out_illegal); // R8
endmodule

// File: tb/sim_rvc_decoder.sv
module sim_rvc_decoder;
    typedef struct {
        logic       vld;
        logic [4:0] op;
        logic [3:0] w;
        logic       s;
        logic       ill;
        string      req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_instr = '0;
    logic        out_valid, out_signed, out_illegal;
    logic [4:0]  out_op;
    logic [3:0]  out_width;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    rvc_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .out_valid(out_valid), .out_op(out_op), .out_width(out_width),
        .out_signed(out_signed), .out_illegal(out_illegal)
    );

    function automatic logic [15:0] mk(input logic [1:0] q, input logic [2:0] f3,
                                       input logic b12, input logic [4:0] rd,
                                       input logic [4:0] rs2);
        return {f3, b12, rd, rs2, q};
    endfunction

    task automatic drive(input logic v, input logic [15:0] ins, input logic [4:0] op,
                         input logic [3:0] w, input logic s, input logic ill, input string req);
        exp_t e;
        @(negedge clk);
        e.vld = v; e.op = op; e.w = w; e.s = s; e.ill = ill; e.req = req;
        exp_q.push_back(e);
        in_valid = v;
        in_instr = ins;
    endtask

    task automatic ok(input logic [15:0] ins, input logic [4:0] op, input logic [3:0] w,
                      input logic s, input string req);
        drive(1'b1, ins, op, w, s, 1'b0, req);
    endtask

    task automatic bad(input logic [15:0] ins, input string req);
        drive(1'b1, ins, 5'd0, 4'd0, 1'b0, 1'b1, req);
    endtask

    // Monitor: compares each registered result against the scoreboard.
    always @(posedge clk) begin
        #2;
        if (rst_n && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_vec++;
            if (out_valid !== e.vld || out_op !== e.op || out_width !== e.w ||
                out_signed !== e.s || out_illegal !== e.ill) begin
                n_bad++;
                $display("FAIL %s: got v=%0b op=%0d w=%0d s=%0b ill=%0b, expected v=%0b op=%0d w=%0d s=%0b ill=%0b",
                         e.req, out_valid, out_op, out_width, out_signed, out_illegal,
                         e.vld, e.op, e.w, e.s, e.ill);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R2: watchdog expired, got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        n_vec++;
        if (out_valid !== 1'b0 || out_op !== 5'd0 || out_width !== 4'd0 ||
            out_signed !== 1'b0 || out_illegal !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: got v=%0b op=%0d w=%0d s=%0b ill=%0b, expected all zero",
                     out_valid, out_op, out_width, out_signed, out_illegal);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R3 quadrant 0
        ok (mk(2'b00, 3'd0, 1'b0, 5'd8, 5'd4), 5'd1, 4'd0, 1'b0, "R3 row0");
        ok (mk(2'b00, 3'd2, 1'b0, 5'd9, 5'd10), 5'd15, 4'd4, 1'b1, "R3 row2");
        ok (mk(2'b00, 3'd3, 1'b1, 5'd9, 5'd10), 5'd15, 4'd8, 1'b0, "R3 row3");
        bad(mk(2'b00, 3'd4, 1'b0, 5'd1, 5'd1), "R3 row4");
        ok (mk(2'b00, 3'd6, 1'b0, 5'd3, 5'd3), 5'd16, 4'd4, 1'b0, "R3 row6");
        ok (mk(2'b00, 3'd7, 1'b1, 5'd3, 5'd3), 5'd16, 4'd8, 1'b0, "R3 row7");
        // R4 floating-point rows
        bad(mk(2'b00, 3'd1, 1'b0, 5'd2, 5'd2), "R4 row1");
        bad(mk(2'b00, 3'd5, 1'b0, 5'd2, 5'd2), "R4 row5");
        bad(mk(2'b10, 3'd1, 1'b0, 5'd2, 5'd2), "R4 row17");
        bad(mk(2'b10, 3'd5, 1'b0, 5'd2, 5'd2), "R4 row21");
        // R2 idle cycle between valid words
        drive(1'b0, 16'h1234, 5'd0, 4'd0, 1'b0, 1'b0, "R2 idle");
        // R5 quadrant 1
        ok (mk(2'b01, 3'd0, 1'b0, 5'd5, 5'd1), 5'd1, 4'd0, 1'b0, "R5 row8");
        ok (mk(2'b01, 3'd1, 1'b0, 5'd5, 5'd1), 5'd2, 4'd0, 1'b0, "R5 row9");
        ok (mk(2'b01, 3'd2, 1'b0, 5'd5, 5'd1), 5'd1, 4'd0, 1'b0, "R5 row10");
        ok (mk(2'b01, 3'd5, 1'b0, 5'd5, 5'd1), 5'd17, 4'd0, 1'b0, "R5 row13");
        ok (mk(2'b01, 3'd6, 1'b0, 5'd5, 5'd1), 5'd19, 4'd0, 1'b0, "R5 row14");
        ok (mk(2'b01, 3'd7, 1'b0, 5'd5, 5'd1), 5'd20, 4'd0, 1'b0, "R5 row15");
        // R6 upper-immediate row
        ok (mk(2'b01, 3'd3, 1'b0, 5'd2, 5'd1), 5'd1, 4'd0, 1'b0, "R6 rd2");
        ok (mk(2'b01, 3'd3, 1'b0, 5'd5, 5'd1), 5'd3, 4'd0, 1'b0, "R6 rd5");
        ok (mk(2'b01, 3'd3, 1'b1, 5'd31, 5'd0), 5'd3, 4'd0, 1'b0, "R6 rd31");
        bad(mk(2'b01, 3'd3, 1'b0, 5'd0, 5'd1), "R6 rd0");
        // R7 arithmetic-misc immediate forms
        ok (mk(2'b01, 3'd4, 1'b0, 5'b00001, 5'd3), 5'd5, 4'd0, 1'b0, "R7 srli");
        ok (mk(2'b01, 3'd4, 1'b0, 5'b01001, 5'd3), 5'd6, 4'd0, 1'b0, "R7 srai");
        ok (mk(2'b01, 3'd4, 1'b1, 5'b10001, 5'd3), 5'd7, 4'd0, 1'b0, "R7 andi");
        // R8 register-register forms
        ok (mk(2'b01, 3'd4, 1'b0, 5'b11001, 5'b00010), 5'd9,  4'd0, 1'b0, "R8 code0");
        ok (mk(2'b01, 3'd4, 1'b0, 5'b11001, 5'b01010), 5'd10, 4'd0, 1'b0, "R8 code1");
        ok (mk(2'b01, 3'd4, 1'b0, 5'b11001, 5'b10010), 5'd11, 4'd0, 1'b0, "R8 code2");
        ok (mk(2'b01, 3'd4, 1'b0, 5'b11001, 5'b11010), 5'd12, 4'd0, 1'b0, "R8 code3");
        ok (mk(2'b01, 3'd4, 1'b1, 5'b11001, 5'b00010), 5'd14, 4'd0, 1'b0, "R8 code4");
        ok (mk(2'b01, 3'd4, 1'b1, 5'b11001, 5'b01010), 5'd13, 4'd0, 1'b0, "R8 code5");
        bad(mk(2'b01, 3'd4, 1'b1, 5'b11001, 5'b10010), "R8 code6");
        bad(mk(2'b01, 3'd4, 1'b1, 5'b11001, 5'b11010), "R8 code7");
        // R9 quadrant 2
        ok (mk(2'b10, 3'd0, 1'b0, 5'd6, 5'd3), 5'd4,  4'd0, 1'b0, "R9 row16");
        ok (mk(2'b10, 3'd2, 1'b0, 5'd6, 5'd3), 5'd15, 4'd4, 1'b1, "R9 row18");
        ok (mk(2'b10, 3'd3, 1'b0, 5'd6, 5'd3), 5'd15, 4'd8, 1'b0, "R9 row19");
        ok (mk(2'b10, 3'd6, 1'b0, 5'd6, 5'd3), 5'd16, 4'd4, 1'b0, "R9 row22");
        ok (mk(2'b10, 3'd7, 1'b0, 5'd6, 5'd3), 5'd16, 4'd8, 1'b0, "R9 row23");
        // R10 jump/move/add row, all eight zero/non-zero codes
        bad(mk(2'b10, 3'd4, 1'b0, 5'd0, 5'd0), "R10 code000");
        bad(mk(2'b10, 3'd4, 1'b0, 5'd0, 5'd3), "R10 code001");
        ok (mk(2'b10, 3'd4, 1'b0, 5'd1, 5'd0), 5'd18, 4'd0, 1'b0, "R10 code010");
        ok (mk(2'b10, 3'd4, 1'b0, 5'd1, 5'd2), 5'd8,  4'd0, 1'b0, "R10 code011");
        bad(mk(2'b10, 3'd4, 1'b1, 5'd0, 5'd0), "R10 code100");
        bad(mk(2'b10, 3'd4, 1'b1, 5'd0, 5'd5), "R10 code101");
        ok (mk(2'b10, 3'd4, 1'b1, 5'd16, 5'd0), 5'd18, 4'd0, 1'b0, "R10 code110");
        ok (mk(2'b10, 3'd4, 1'b1, 5'd1, 5'd16), 5'd8, 4'd0, 1'b0, "R10 code111");
        // R11 illegal result follows an active memory result
        ok (mk(2'b00, 3'd2, 1'b0, 5'd1, 5'd1), 5'd15, 4'd4, 1'b1, "R11 before");
        bad(mk(2'b00, 3'd1, 1'b1, 5'd1, 5'd1), "R11 clean");
        drive(1'b0, 16'h0000, 5'd0, 4'd0, 1'b0, 1'b0, "R2 trailing idle");

        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule